// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a slower line-wide memory. Every request is looked up in two ways at once, using the same set index. Two tag comparators and a 2:1 multiplexer return the word from the way that matches. A hit, whether a load or a store, completes in the same cycle with no stall. Stores change only the cached copy and mark the line as modified. Memory is written only when a modified line is displaced.

On a miss the processor is stalled and must hold its request until the stall drops. A single victim buffer holds a displaced modified line, so the line fetch for the miss goes to memory first and the writeback waits. The buffer is drained when the processor issues no request. If a miss asks for the line sitting in the buffer, it is refilled from the buffer with no memory traffic.

Top module: `two_way_cache`

## Requirements
- R1: A byte address splits into tag = addr[31:12], set index = addr[11:5] (128 sets) and word select = addr[4:2]. A load that hits returns the selected 32-bit word in the same cycle with cpuStall low.
- R2: Lines with different tags in the same set are held in separate ways. At most one way matches a lookup, and the returned word comes from the matching way.
- R3: A store hit replaces only the addressed word, marks the line modified and causes no memory transaction. The stored value is what a later load and a later writeback see.
- R4: On a miss, cpuStall stays high and exactly one line read (memWe = 0) is issued at line address addr[31:5]. After memAck the line is installed and the held request completes as a hit. A store miss allocates the line first, then merges the word.
- R5: A miss fills an invalid way before any valid way in the set is displaced.
- R6: With both ways valid, the victim is the way not accessed most recently in that set. Every hit and every fill counts as an access.
- R7: A modified victim moves to the victim buffer. It is written to memory (memWe = 1) at its own line address only after the line read for the miss that displaced it, and only when the processor is idle or a later miss needs the buffer. The written line carries all merged stores.
- R8: An unmodified victim is dropped without any memory write.
- R9: A miss whose line address equals the buffered line is refilled from the buffer with no memory transaction. The line stays marked modified.
- R10: A miss whose victim is modified while the buffer is already occupied first writes out the buffered line, then issues its own line read.
- R11: After reset every line is invalid and the buffer is empty. With no request, cpuStall and memReq are low, and the first access to any address misses.
- R12: memReq, memAddr and memWe hold steady from the start of a transaction until the cycle in which memAck is high. memAck is a one-cycle pulse that ends the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request valid, held while stalled |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid when cpuReq and not cpuStall |
| cpuStall | output | 1 | Request not finished this cycle |
| memReq | output | 1 | Line transaction request to memory |
| memWe | output | 1 | 1 = line write, 0 = line read |
| memAddr | output | 27 | Line address (byte address bits 31:5) |
| memWline | output | 256 | Line written to memory |
| memRline | input | 256 | Line returned by memory, valid with memAck |
| memAck | input | 1 | One-cycle completion of a memory transaction |

## Verification
Faults in the replacement bit, the modified flags or the victim buffer do not show at once. They show later, as a memory transaction that is extra, missing or out of order on the line port, and usually appear at the next miss to the same set. The bench therefore logs every memory transaction and compares the exact sequence of line reads and writes for each scenario. It checks loaded words, and words written back to memory, against a model built only from the processor's own stores. A lost store or a wrong refill source shows up as wrong data as soon as the line is loaded again or written back.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int ADDR_W   = 32;
  localparam int WORD_W   = 32;
  localparam int OFFSET_W = 5;
  localparam int INDEX_W  = 7;
  localparam int NUM_WAYS = 2;

  localparam int TAG_W    = ADDR_W - OFFSET_W - INDEX_W;
  localparam int LINE_A_W = ADDR_W - OFFSET_W;
  localparam int SETS     = 1 << INDEX_W;
  localparam int LINE_W   = 8 * (1 << OFFSET_W);
  localparam int WORDS    = LINE_W / WORD_W;
  localparam int WSEL_W   = $clog2(WORDS);
  localparam int BSEL_W   = $clog2(WORD_W / 8);
  localparam int WBIT_W   = $clog2(WORD_W);
  localparam int LIDX_W   = WSEL_W + WBIT_W;

  typedef struct packed {
    logic hitAccess;
    logic startMiss;
    logic memFill;
    logic wbRefill;
    logic wbRetire;
    logic drainSel;
  } ctlStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } ctlStateT;
endpackage

// File: rtl/cache_dp.sv
module cache_dp
  import cache_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobeT            strobe,
  input  logic                 cpuWe,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [WORD_W-1:0]    cpuWdata,
  output logic [WORD_W-1:0]    cpuRdata,
  input  logic [LINE_W-1:0]    memRline,
  output logic [LINE_A_W-1:0]  memAddr,
  output logic [LINE_W-1:0]    memWline,
  output logic [NUM_WAYS-1:0]  hitVec,
  output logic                 hitAny,
  output logic                 victimDirty,
  output logic                 wbValid,
  output logic                 wbMatch
);
  logic [TAG_W-1:0]  tagArr  [NUM_WAYS][SETS];
  logic [LINE_W-1:0] dataArr [NUM_WAYS][SETS];
  logic [SETS-1:0]   validArr [NUM_WAYS];
  logic [SETS-1:0]   dirtyArr [NUM_WAYS];
  logic [SETS-1:0]   lruArr;

  logic [LINE_A_W-1:0] wbAddr;
  logic [LINE_W-1:0]   wbLine;
  logic                fillWay;

  logic [TAG_W-1:0]    tagIn;
  logic [INDEX_W-1:0]  idx;
  logic [WSEL_W-1:0]   wordSel;
  logic [LINE_A_W-1:0] lineIn;
  logic [LIDX_W-1:0]   wordBase;
  logic                unusedByteBits;

  assign tagIn    = cpuAddr[ADDR_W-1 -: TAG_W];
  assign idx      = cpuAddr[OFFSET_W +: INDEX_W];
  assign wordSel  = cpuAddr[BSEL_W +: WSEL_W];
  assign lineIn   = cpuAddr[ADDR_W-1:OFFSET_W];
  assign wordBase = {wordSel, {WBIT_W{1'b0}}};
  assign unusedByteBits = ^cpuAddr[BSEL_W-1:0];

  logic [TAG_W-1:0]    rdTag  [NUM_WAYS];
  logic [LINE_W-1:0]   rdLine [NUM_WAYS];
  logic [NUM_WAYS-1:0] rdValid;
  logic [NUM_WAYS-1:0] rdDirty;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign rdTag[w]   = tagArr[w][idx];
    assign rdLine[w]  = dataArr[w][idx];
    assign rdValid[w] = validArr[w][idx];
    assign rdDirty[w] = dirtyArr[w][idx];
    assign hitVec[w]  = rdValid[w] && (rdTag[w] == tagIn);
  end

  logic              hitWay;
  logic              victimWay;
  logic [LINE_W-1:0] hitLine;
  logic [LINE_W-1:0] mergedLine;

  assign hitAny   = |hitVec;
  assign hitWay   = hitVec[1];
  assign hitLine  = hitWay ? rdLine[1] : rdLine[0];
  assign cpuRdata = hitLine[wordBase +: WORD_W];

  // invalid ways first, then the least recently used one
  assign victimWay   = !rdValid[0] ? 1'b0 : (!rdValid[1] ? 1'b1 : lruArr[idx]);
  assign victimDirty = rdValid[victimWay] && rdDirty[victimWay];
  assign wbMatch     = wbValid && (wbAddr == lineIn);
  assign memAddr     = strobe.drainSel ? wbAddr : lineIn;
  assign memWline    = wbLine;

  always_comb begin
    mergedLine = hitLine;
    mergedLine[wordBase +: WORD_W] = cpuWdata;
  end

  always_ff @(posedge clk) begin
    if (strobe.hitAccess && cpuWe) dataArr[hitWay][idx] <= mergedLine;
    if (strobe.memFill) begin
      dataArr[fillWay][idx] <= memRline;
      tagArr[fillWay][idx]  <= tagIn;
    end
    if (strobe.wbRefill) begin
      dataArr[victimWay][idx] <= wbLine;
      tagArr[victimWay][idx]  <= tagIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        validArr[w] <= '0;
        dirtyArr[w] <= '0;
      end
      lruArr  <= '0;
      wbValid <= 1'b0;
      wbAddr  <= '0;
      wbLine  <= '0;
      fillWay <= 1'b0;
    end else begin
      if (strobe.hitAccess) begin
        lruArr[idx] <= ~hitWay;
        if (cpuWe) dirtyArr[hitWay][idx] <= 1'b1;
      end
      if (strobe.startMiss) begin
        fillWay <= victimWay;
        validArr[victimWay][idx] <= 1'b0;
        if (victimDirty) begin
          wbValid <= 1'b1;
          wbAddr  <= {rdTag[victimWay], idx};
          wbLine  <= rdLine[victimWay];
        end
      end
      if (strobe.memFill) begin
        validArr[fillWay][idx] <= 1'b1;
        dirtyArr[fillWay][idx] <= 1'b0;
        lruArr[idx]            <= ~fillWay;
      end
      if (strobe.wbRefill) begin
        validArr[victimWay][idx] <= 1'b1;
        dirtyArr[victimWay][idx] <= 1'b1;
        lruArr[idx]              <= ~victimWay;
        if (victimDirty) begin
          wbAddr <= {rdTag[victimWay], idx};
          wbLine <= rdLine[victimWay];
        end else begin
          wbValid <= 1'b0;
        end
      end
      if (strobe.wbRetire) wbValid <= 1'b0;
    end
  end
endmodule

// File: rtl/cache_ctl.sv
module cache_ctl
  import cache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      hitAny,
  input  logic      victimDirty,
  input  logic      wbValid,
  input  logic      wbMatch,
  input  logic      memAck,
  output ctlStrobeT strobe,
  output logic      cpuStall,
  output logic      memReq,
  output logic      memWe
);
  ctlStateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    cpuStall  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (hitAny) begin
            strobe.hitAccess = 1'b1;
          end else begin
            cpuStall = 1'b1;
            if (wbMatch)                    strobe.wbRefill = 1'b1;
            else if (victimDirty && wbValid) nextState = ST_DRAIN;
            else begin
              strobe.startMiss = 1'b1;
              nextState        = ST_FILL;
            end
          end
        end else if (wbValid) begin
          nextState = ST_DRAIN;
        end
      end
      ST_FILL: begin
        cpuStall = cpuReq;
        memReq   = 1'b1;
        if (memAck) begin
          strobe.memFill = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      ST_DRAIN: begin
        memReq          = 1'b1;
        memWe           = 1'b1;
        strobe.drainSel = 1'b1;
        if (cpuReq) begin
          if (hitAny) strobe.hitAccess = 1'b1;
          else        cpuStall = 1'b1;
        end
        if (memAck) begin
          strobe.wbRetire = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/two_way_cache.sv
module two_way_cache
  import cache_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuReq,
  input  logic                cpuWe,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [WORD_W-1:0]   cpuWdata,
  output logic [WORD_W-1:0]   cpuRdata,
  output logic                cpuStall,
  output logic                memReq,
  output logic                memWe,
  output logic [LINE_A_W-1:0] memAddr,
  output logic [LINE_W-1:0]   memWline,
  input  logic [LINE_W-1:0]   memRline,
  input  logic                memAck
);
  ctlStrobeT           strobe;
  logic [NUM_WAYS-1:0] hitVec;
  logic                hitAny;
  logic                victimDirty;
  logic                wbValid;
  logic                wbMatch;

  cache_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .memRline(memRline), .memAddr(memAddr), .memWline(memWline),
    .hitVec(hitVec), .hitAny(hitAny), .victimDirty(victimDirty),
    .wbValid(wbValid), .wbMatch(wbMatch)
  );

  cache_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .hitAny(hitAny),
    .victimDirty(victimDirty), .wbValid(wbValid), .wbMatch(wbMatch),
    .memAck(memAck), .strobe(strobe), .cpuStall(cpuStall),
    .memReq(memReq), .memWe(memWe)
  );
endmodule

// File: rtl/cache_chk.sv
module cache_chk
  import cache_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                cpuReq,
  input logic                cpuStall,
  input logic                memReq,
  input logic                memWe,
  input logic                memAck,
  input logic [LINE_A_W-1:0] memAddr,
  input logic [NUM_WAYS-1:0] hitVec,
  input logic                wbValid
);
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  p_one_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  p_miss_stall_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !(|hitVec) |-> cpuStall);

  p_fill_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && !memWe && cpuReq |=> |hitVec);

  p_write_from_buf_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> wbValid);
endmodule

bind two_way_cache cache_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuStall(cpuStall),
  .memReq(memReq), .memWe(memWe), .memAck(memAck), .memAddr(memAddr),
  .hitVec(hitVec), .wbValid(wbValid)
);

// File: tb/test_two_way_cache.sv
module test_two_way_cache;
  import cache_pkg::*;

  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rstN;
  logic                cpuReq, cpuWe;
  logic [ADDR_W-1:0]   cpuAddr;
  logic [WORD_W-1:0]   cpuWdata, cpuRdata;
  logic                cpuStall, memReq, memWe, memAck;
  logic [LINE_A_W-1:0] memAddr;
  logic [LINE_W-1:0]   memWline, memRline;

  two_way_cache i_two_way_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuStall(cpuStall),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWline(memWline),
    .memRline(memRline), .memAck(memAck)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [LINE_W-1:0]   memLines [logic [LINE_A_W-1:0]];
  logic [WORD_W-1:0]   gold     [logic [ADDR_W-1:0]];
  logic                opWe   [0:63];
  logic [LINE_A_W-1:0] opAddr [0:63];
  int                  opCnt = 0;

  function automatic logic [LINE_W-1:0] pattLine(input logic [LINE_A_W-1:0] la);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WORDS; w++) l[w*WORD_W +: WORD_W] = {la[23:0], 8'(w)} ^ 32'h3C00_0000;
    return l;
  endfunction

  function automatic logic [LINE_W-1:0] memFetch(input logic [LINE_A_W-1:0] la);
    if (memLines.exists(la)) return memLines[la];
    return pattLine(la);
  endfunction

  function automatic logic [WORD_W-1:0] goldWord(input logic [ADDR_W-1:0] a);
    logic [LINE_W-1:0] l;
    if (gold.exists(a)) return gold[a];
    l = pattLine(a[ADDR_W-1:OFFSET_W]);
    return l[int'(a[4:2])*WORD_W +: WORD_W];
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int w);
    return {t[19:0], s[6:0], w[2:0], 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: fixed latency, one-cycle ack driven at the falling edge
  initial begin
    int lat = 0;
    logic [LINE_A_W-1:0] reqAddr = '0;
    logic reqWe = 1'b0;
    memAck   = 1'b0;
    memRline = '0;
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memReq && rstN) begin
        lat++;
        if (lat == 1) begin
          reqAddr = memAddr;
          reqWe   = memWe;
        end
        if (lat == MEM_LAT) begin
          lat = 0;
          check(memAddr == reqAddr && memWe == reqWe, "R12", "request held steady",
                32'({memWe, memAddr}), 32'({reqWe, reqAddr}));
          if (opCnt < 64) begin
            opWe[opCnt]   = memWe;
            opAddr[opCnt] = memAddr;
          end
          opCnt++;
          if (memWe) memLines[memAddr] = memWline;
          else       memRline = memFetch(memAddr);
          memAck = 1'b1;
        end
      end else begin
        lat = 0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cycles, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stallCyc);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = wd;
    stallCyc = 0;
    #2;
    while (cpuStall && stallCyc < 1000) begin
      stallCyc++;
      @(negedge clk);
      #2;
    end
    rd = cpuRdata;
    if (we) gold[a] = wd;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic rdCheck(input logic [31:0] a, input string req, output int st);
    logic [31:0] rd;
    access(1'b0, a, 32'h0, rd, st);
    check(rd == goldWord(a), req, "load data", rd, goldWord(a));
  endtask

  task automatic opCheck(input int i, input bit we, input logic [31:0] a, input string req);
    logic [LINE_A_W-1:0] la;
    la = a[ADDR_W-1:OFFSET_W];
    check(i < opCnt && opWe[i] == we && opAddr[i] == la, req, $sformatf("mem op %0d", i),
          32'({opWe[i], opAddr[i]}), 32'({we, la}));
  endtask

  task automatic t_reset();
    check(!cpuStall, "R11", "idle stall after reset", 32'(cpuStall), 32'd0);
    check(!memReq, "R11", "idle memReq after reset", 32'(memReq), 32'd0);
  endtask

  task automatic t_cold_miss();
    int st, m;
    m = opCnt;
    rdCheck(mk(1, 5, 2), "R4", st);
    check(st > 0, "R11", "first access misses", 32'(st), 32'd1);
    check(opCnt == m + 1, "R4", "one line read", 32'(opCnt - m), 32'd1);
    opCheck(m, 1'b0, mk(1, 5, 0), "R4");
    rdCheck(mk(1, 5, 6), "R1", st);
    check(st == 0, "R1", "hit without stall", 32'(st), 32'd0);
  endtask

  task automatic t_two_ways();
    int st, m;
    rdCheck(mk(2, 5, 1), "R2", st);
    m = opCnt;
    rdCheck(mk(1, 5, 3), "R2", st);
    check(st == 0, "R5", "first line kept in other way", 32'(st), 32'd0);
    rdCheck(mk(2, 5, 7), "R2", st);
    check(st == 0, "R5", "second line hits", 32'(st), 32'd0);
    check(opCnt == m, "R5", "no traffic for resident lines", 32'(opCnt - m), 32'd0);
  endtask

  task automatic t_store_hit();
    int st, m;
    logic [31:0] rd;
    m = opCnt;
    access(1'b1, mk(1, 5, 2), 32'hDEAD_BEEF, rd, st);
    check(st == 0, "R3", "store hit no stall", 32'(st), 32'd0);
    rdCheck(mk(1, 5, 2), "R3", st);
    rdCheck(mk(1, 5, 3), "R3", st);
    check(opCnt == m, "R3", "store hit no memory traffic", 32'(opCnt - m), 32'd0);
  endtask

  task automatic t_lru();
    int st, m;
    rdCheck(mk(1, 5, 0), "R6", st);
    m = opCnt;
    rdCheck(mk(3, 5, 4), "R6", st);
    check(opCnt == m + 1, "R8", "clean victim not written", 32'(opCnt - m), 32'd1);
    opCheck(m, 1'b0, mk(3, 5, 0), "R8");
    rdCheck(mk(1, 5, 2), "R6", st);
    check(st == 0, "R6", "recently used line kept", 32'(st), 32'd0);
    rdCheck(mk(2, 5, 1), "R6", st);
    check(st > 0, "R6", "older line was replaced", 32'(st), 32'd1);
  endtask

  task automatic t_dirty_evict();
    int st, m;
    logic [LINE_W-1:0] l;
    m = opCnt;
    rdCheck(mk(4, 5, 5), "R7", st);
    idle(12);
    check(opCnt == m + 2, "R7", "read then writeback", 32'(opCnt - m), 32'd2);
    opCheck(m, 1'b0, mk(4, 5, 0), "R7");
    opCheck(m + 1, 1'b1, mk(1, 5, 0), "R7");
    l = memFetch(mk(1, 5, 0) >> OFFSET_W);
    check(l[2*WORD_W +: WORD_W] == 32'hDEAD_BEEF, "R3", "stored word written back",
          l[2*WORD_W +: WORD_W], 32'hDEAD_BEEF);
  endtask

  task automatic t_buffer_hit();
    int st, m;
    logic [31:0] rd;
    m = opCnt;
    access(1'b1, mk(5, 9, 1), 32'h1111_2222, rd, st);
    check(st > 0, "R4", "store miss stalls", 32'(st), 32'd1);
    opCheck(m, 1'b0, mk(5, 9, 0), "R4");
    rdCheck(mk(5, 9, 1), "R4", st);
    rdCheck(mk(6, 9, 0), "R9", st);
    rdCheck(mk(7, 9, 0), "R9", st);
    m = opCnt;
    rdCheck(mk(5, 9, 1), "R9", st);
    check(opCnt == m, "R9", "refill from buffer without traffic", 32'(opCnt - m), 32'd0);
  endtask

  task automatic t_drain_first();
    int st, m;
    logic [31:0] rd;
    logic [LINE_W-1:0] l;
    access(1'b1, mk(7, 9, 0), 32'h7777_0000, rd, st);
    access(1'b1, mk(8, 12, 3), 32'h8888_0003, rd, st);
    access(1'b1, mk(9, 12, 3), 32'h9999_0003, rd, st);
    m = opCnt;
    rdCheck(mk(10, 12, 0), "R10", st);
    rdCheck(mk(11, 9, 0), "R10", st);
    idle(12);
    check(opCnt == m + 4, "R10", "transaction count", 32'(opCnt - m), 32'd4);
    opCheck(m, 1'b0, mk(10, 12, 0), "R7");
    opCheck(m + 1, 1'b1, mk(8, 12, 0), "R10");
    opCheck(m + 2, 1'b0, mk(11, 9, 0), "R10");
    opCheck(m + 3, 1'b1, mk(5, 9, 0), "R7");
    l = memFetch(mk(8, 12, 0) >> OFFSET_W);
    check(l[3*WORD_W +: WORD_W] == 32'h8888_0003, "R10", "buffered line contents",
          l[3*WORD_W +: WORD_W], 32'h8888_0003);
  endtask

  task automatic t_data_return();
    int st;
    rdCheck(mk(5, 9, 1), "R7", st);
    check(st > 0, "R7", "written-back line refetched", 32'(st), 32'd1);
    rdCheck(mk(8, 12, 3), "R10", st);
    rdCheck(mk(7, 9, 0), "R3", st);
    idle(12);
  endtask

  initial begin
    rstN = 1'b0; cpuReq = 1'b0; cpuWe = 1'b0; cpuAddr = '0; cpuWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    t_reset();
    t_cold_miss();
    t_two_ways();
    t_store_hit();
    t_lru();
    t_dirty_evict();
    t_buffer_hit();
    t_drain_first();
    t_data_return();
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule